// File: doc/BRIEF.md
# Octal Flash Bring-Up Sequencer

This block is a hardware state machine that takes a serial NOR flash from its power-on single-line state into octal operation, either single-rate or double-rate. It first screens the identification code it is handed; a part it does not recognise is rejected at once, with no bus traffic. For an accepted part it waits for the flash to go idle, raises the flash output drive strength with a read-modify-write of the status and configuration registers, waits for idle again, and in double-rate mode reads two bytes of the discoverable parameter table to learn whether the part delivers double-rate data with its bytes swapped. It ends by writing configuration register 2 to select the octal mode.

Every flash access goes through an external single-line command engine. The sequencer raises a request carrying opcode, address length, address, dummy count, transmit data with its bit length, and receive bit length. It holds all of these steady until the engine returns a one-cycle done pulse with any received byte. At the end the sequencer gives a one-cycle completion pulse, together with a held swap flag and held error flags.

Top module: `octflash_bringup`

## Requirements
- R1: A start is accepted only when id[23:16] is 0xC2 and id[15:12] is 0x8. Any other code ends the run with `seq_done` and `seq_err_id` high and no command request.
- R2: `cmd_req` stays high with every command field unchanged from the cycle it rises until the cycle `cmd_done` is seen. It is low for at least one cycle after each done.
- R3: Each wait-for-idle issues opcode 0x05 (address length 0, no dummy, no transmit data, 8 receive bits) and repeats it while bit 0 of the returned byte is 1. If MAX_POLLS polls in a row all return busy, the run ends with `seq_err_timeout`, and no further command follows.
- R4: The drive step reads the status register with opcode 0x05 and then the configuration register with opcode 0x15. Both reads have address length 0, 0 dummy cycles and 8 receive bits.
- R5: The drive step then issues write-enable, opcode 0x06 with no address and no data, followed by opcode 0x01 with 16 transmit bits. Data bits [7:0] carry the status byte read back, and bits [15:8] carry the configuration byte with bits [2:0] replaced by DRIVE_CODE (default 7).
- R6: In double-rate mode the sequencer issues opcode 0x5A with a 24-bit address of 0x0C, 8 dummy cycles and 8 receive bits. It then issues opcode 0x5A at 24-bit address (first byte + 0x47). Bit 7 of the second byte becomes `swap_en`.
- R7: The mode write is write-enable, then opcode 0x72 with a 32-bit address of 0, no dummy cycles and 8 transmit bits. The data byte is 0x01 for single-rate mode (`dtr_mode`=0) and 0x02 for double-rate mode (`dtr_mode`=1).
- R8: The order is: poll, status read, configuration read, write-enable, status/configuration write, poll, then the two parameter reads (double-rate only), write-enable and mode write.
- R9: In single-rate mode no 0x5A command is issued and `swap_en` is 0 at completion.
- R10: `seq_done` is a one-cycle pulse. `swap_en` and the error flags hold until the next accepted start. A start while a run is in progress is ignored. All outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a bring-up run (sampled when idle) |
| jedec_id | input | 24 | Identification code of the attached flash |
| dtr_mode | input | 1 | 1 selects octal double-rate, 0 octal single-rate |
| cmd_req | output | 1 | Command request to the engine |
| cmd_opcode | output | 8 | Command opcode |
| cmd_addr_len | output | 6 | Address length in bits: 0, 24 or 32 |
| cmd_addr | output | 32 | Command address |
| cmd_dummy | output | 4 | Dummy cycle count |
| cmd_tx_data | output | 16 | Transmit data, low byte first |
| cmd_tx_bits | output | 5 | Transmit bit count |
| cmd_rx_bits | output | 5 | Receive bit count |
| cmd_done | input | 1 | Engine completion pulse |
| cmd_rx_data | input | 8 | Byte received by the engine, valid with cmd_done |
| seq_done | output | 1 | One-cycle completion pulse |
| seq_err_id | output | 1 | Unsupported identification code |
| seq_err_timeout | output | 1 | Flash stayed busy for MAX_POLLS polls |
| swap_en | output | 1 | Double-rate byte order needs swapping |

## Verification
The assertions assume that the command engine raises `cmd_done` only while `cmd_req` is high, once per request, with `cmd_rx_data` valid in that same cycle. They also assume that `jedec_id` and `dtr_mode` are valid in the cycle `start` is high. The bench's engine model waits for a request, answers two cycles later with a single done pulse and the byte its register model returns, and then waits for the request to fall. The bench drives `start` as a one-cycle pulse together with the identity and mode, so the stimulus never steps outside these assumptions, including the stray start it sends in the middle of a run.

// File: rtl/octflash_pkg.sv
package octflash_pkg;

  localparam int OPC_W  = 8;
  localparam int ALEN_W = 6;
  localparam int ADDR_W = 32;
  localparam int DUM_W  = 4;
  localparam int TXD_W  = 16;
  localparam int BITS_W = 5;
  localparam int RXD_W  = 8;
  localparam int ID_W   = 24;

  localparam logic [OPC_W-1:0] OP_RDSR   = 8'h05;
  localparam logic [OPC_W-1:0] OP_RDCR   = 8'h15;
  localparam logic [OPC_W-1:0] OP_WREN   = 8'h06;
  localparam logic [OPC_W-1:0] OP_WRSRCR = 8'h01;
  localparam logic [OPC_W-1:0] OP_WRCR2  = 8'h72;
  localparam logic [OPC_W-1:0] OP_SFDP   = 8'h5A;

  localparam logic [7:0]        VENDOR_CODE   = 8'hC2;
  localparam logic [3:0]        OCTAL_TYPE    = 4'h8;
  localparam logic [ADDR_W-1:0] PTAB_PTR_ADDR = 32'h0000_000C;
  localparam logic [ADDR_W-1:0] ORDER_OFFSET  = 32'h0000_0047;

  typedef enum logic [3:0] {
    ST_IDLE, ST_POLL_A, ST_RD_SR, ST_RD_CR, ST_WEN_A, ST_WR_SRCR,
    ST_POLL_B, ST_PTAB_PTR, ST_PTAB_ORD, ST_WEN_B, ST_WR_MODE
  } step_t;

  typedef struct packed {
    logic [OPC_W-1:0]  op;
    logic [ALEN_W-1:0] alen;
    logic [ADDR_W-1:0] addr;
    logic [DUM_W-1:0]  dummy;
    logic [TXD_W-1:0]  tx;
    logic [BITS_W-1:0] txb;
    logic [BITS_W-1:0] rxb;
  } cmd_t;

  function automatic logic id_supported(input logic [ID_W-1:0] id);
    return (id[23:16] == VENDOR_CODE) && (id[15:12] == OCTAL_TYPE);
  endfunction

  function automatic logic [7:0] drive_merge(input logic [7:0] cr, input logic [2:0] code);
    return {cr[7:3], code};
  endfunction

  function automatic logic [ADDR_W-1:0] order_addr(input logic [7:0] base);
    return {24'h0, base} + ORDER_OFFSET;
  endfunction

  function automatic logic [7:0] mode_byte(input logic dtr);
    return dtr ? 8'h02 : 8'h01;
  endfunction

  function automatic step_t next_step(input step_t s, input logic dtr);
    case (s)
      ST_POLL_A:   return ST_RD_SR;
      ST_RD_SR:    return ST_RD_CR;
      ST_RD_CR:    return ST_WEN_A;
      ST_WEN_A:    return ST_WR_SRCR;
      ST_WR_SRCR:  return ST_POLL_B;
      ST_POLL_B:   return dtr ? ST_PTAB_PTR : ST_WEN_B;
      ST_PTAB_PTR: return ST_PTAB_ORD;
      ST_PTAB_ORD: return ST_WEN_B;
      ST_WEN_B:    return ST_WR_MODE;
      default:     return ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/octflash_idcheck.sv
module octflash_idcheck
  import octflash_pkg::*;
(
  input  logic [ID_W-1:0] id,
  output logic            ok
);
  assign ok = id_supported(id);
endmodule

// File: rtl/octflash_pollctr.sv
module octflash_pollctr #(
  parameter int MAX_POLLS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic hit,
  output logic last
);
  localparam int CW = $clog2(MAX_POLLS + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(MAX_POLLS - 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(MAX_POLLS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (hit) cnt_q <= cnt_q + 1'b1;
  end

  assign last = (cnt_q == LAST_IDX);

  AST_POLL_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX); // R3
  AST_POLL_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !clr) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R3
endmodule

// File: rtl/octflash_cmdfmt.sv
module octflash_cmdfmt
  import octflash_pkg::*;
#(
  parameter logic [2:0] DRIVE_CODE = 3'd7
) (
  input  step_t      step,
  input  logic       dtr,
  input  logic [7:0] sr,
  input  logic [7:0] cr,
  input  logic [7:0] base,
  output cmd_t       cmd
);
  always_comb begin
    cmd = '0;
    case (step)
      ST_POLL_A, ST_POLL_B, ST_RD_SR: begin
        cmd.op  = OP_RDSR;
        cmd.rxb = BITS_W'(8);
      end
      ST_RD_CR: begin
        cmd.op  = OP_RDCR;
        cmd.rxb = BITS_W'(8);
      end
      ST_WEN_A, ST_WEN_B: cmd.op = OP_WREN;
      ST_WR_SRCR: begin
        cmd.op  = OP_WRSRCR;
        cmd.tx  = {drive_merge(cr, DRIVE_CODE), sr};
        cmd.txb = BITS_W'(16);
      end
      ST_PTAB_PTR, ST_PTAB_ORD: begin
        cmd.op    = OP_SFDP;
        cmd.alen  = ALEN_W'(24);
        cmd.addr  = (step == ST_PTAB_PTR) ? PTAB_PTR_ADDR : order_addr(base);
        cmd.dummy = DUM_W'(8);
        cmd.rxb   = BITS_W'(8);
      end
      ST_WR_MODE: begin
        cmd.op   = OP_WRCR2;
        cmd.alen = ALEN_W'(32);
        cmd.tx   = {8'h00, mode_byte(dtr)};
        cmd.txb  = BITS_W'(8);
      end
      default: cmd = '0;
    endcase
  end
endmodule

// File: rtl/octflash_bringup.sv
module octflash_bringup
  import octflash_pkg::*;
#(
  parameter int         MAX_POLLS  = 8,
  parameter logic [2:0] DRIVE_CODE = 3'd7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ID_W-1:0]   jedec_id,
  input  logic              dtr_mode,
  output logic              cmd_req,
  output logic [OPC_W-1:0]  cmd_opcode,
  output logic [ALEN_W-1:0] cmd_addr_len,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DUM_W-1:0]  cmd_dummy,
  output logic [TXD_W-1:0]  cmd_tx_data,
  output logic [BITS_W-1:0] cmd_tx_bits,
  output logic [BITS_W-1:0] cmd_rx_bits,
  input  logic              cmd_done,
  input  logic [RXD_W-1:0]  cmd_rx_data,
  output logic              seq_done,
  output logic              seq_err_id,
  output logic              seq_err_timeout,
  output logic              swap_en
);
  step_t      state;
  logic       req_q, mode_q, ord7_q;
  logic [7:0] sr_q, cr_q, base_q;
  logic       done_q, err_id_q, err_to_q, swap_q;
  cmd_t       cmd;

  // Named internal events
  logic id_ok, poll_last, done_evt, in_poll, poll_busy, poll_clr, poll_hit;

  assign done_evt  = req_q && cmd_done;
  assign in_poll   = (state == ST_POLL_A) || (state == ST_POLL_B);
  assign poll_busy = in_poll && cmd_rx_data[0];
  assign poll_clr  = (state == ST_IDLE) || (done_evt && !poll_busy);
  assign poll_hit  = done_evt && poll_busy;

  octflash_idcheck u_id (.id(jedec_id), .ok(id_ok));

  octflash_pollctr #(.MAX_POLLS(MAX_POLLS)) u_poll (
    .clk(clk), .rst_n(rst_n), .clr(poll_clr), .hit(poll_hit), .last(poll_last)
  );

  octflash_cmdfmt #(.DRIVE_CODE(DRIVE_CODE)) u_fmt (
    .step(state), .dtr(mode_q), .sr(sr_q), .cr(cr_q), .base(base_q), .cmd(cmd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      req_q    <= 1'b0;
      mode_q   <= 1'b0;
      ord7_q   <= 1'b0;
      sr_q     <= '0;
      cr_q     <= '0;
      base_q   <= '0;
      done_q   <= 1'b0;
      err_id_q <= 1'b0;
      err_to_q <= 1'b0;
      swap_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            mode_q   <= dtr_mode;
            ord7_q   <= 1'b0;
            err_id_q <= 1'b0;
            err_to_q <= 1'b0;
            if (id_ok) begin
              state <= ST_POLL_A;
            end else begin
              done_q   <= 1'b1;
              err_id_q <= 1'b1;
              swap_q   <= 1'b0;
            end
          end
        end
        default: begin
          if (!req_q) begin
            req_q <= 1'b1;
          end else if (cmd_done) begin
            req_q <= 1'b0;
            if (poll_busy) begin
              if (poll_last) begin
                state    <= ST_IDLE;
                done_q   <= 1'b1;
                err_to_q <= 1'b1;
                swap_q   <= 1'b0;
              end
            end else begin
              case (state)
                ST_RD_SR:    sr_q   <= cmd_rx_data;
                ST_RD_CR:    cr_q   <= cmd_rx_data;
                ST_PTAB_PTR: base_q <= cmd_rx_data;
                ST_PTAB_ORD: ord7_q <= cmd_rx_data[7];
                default: ;
              endcase
              if (state == ST_WR_MODE) begin
                state  <= ST_IDLE;
                done_q <= 1'b1;
                swap_q <= mode_q & ord7_q;
              end else begin
                state <= next_step(state, mode_q);
              end
            end
          end
        end
      endcase
    end
  end

  assign cmd_req         = req_q;
  assign cmd_opcode      = cmd.op;
  assign cmd_addr_len    = cmd.alen;
  assign cmd_addr        = cmd.addr;
  assign cmd_dummy       = cmd.dummy;
  assign cmd_tx_data     = cmd.tx;
  assign cmd_tx_bits     = cmd.txb;
  assign cmd_rx_bits     = cmd.rxb;
  assign seq_done        = done_q;
  assign seq_err_id      = err_id_q;
  assign seq_err_timeout = err_to_q;
  assign swap_en         = swap_q;

  AST_BAD_ID_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start && !id_ok) |=> (seq_done && seq_err_id && !cmd_req)); // R1
  AST_REQ_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !cmd_done) |=> (cmd_req && $stable(cmd_opcode) && $stable(cmd_addr)
                                && $stable(cmd_tx_data) && $stable(cmd_addr_len))); // R2
  AST_REQ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && cmd_done) |=> !cmd_req); // R2
  AST_TIMEOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err_timeout |-> !cmd_req); // R3
  AST_NO_PROBE_STR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && cmd_opcode == OP_SFDP) |-> mode_q); // R9
  AST_STR_NO_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && !mode_q) |-> !swap_en); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done); // R10
  AST_ONE_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_err_id && seq_err_timeout)); // R10
endmodule

// File: tb/octflash_bringup_test.sv
module octflash_bringup_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] jedec_id = '0;
  logic        dtr_mode = 1'b0;
  logic        cmd_req;
  logic [7:0]  cmd_opcode;
  logic [5:0]  cmd_addr_len;
  logic [31:0] cmd_addr;
  logic [3:0]  cmd_dummy;
  logic [15:0] cmd_tx_data;
  logic [4:0]  cmd_tx_bits;
  logic [4:0]  cmd_rx_bits;
  logic        cmd_done = 1'b0;
  logic [7:0]  cmd_rx_data = '0;
  logic        seq_done, seq_err_id, seq_err_timeout, swap_en;

  always #4 clk = ~clk;

  octflash_bringup uut (
    .clk(clk), .rst_n(rst_n), .start(start), .jedec_id(jedec_id), .dtr_mode(dtr_mode),
    .cmd_req(cmd_req), .cmd_opcode(cmd_opcode), .cmd_addr_len(cmd_addr_len),
    .cmd_addr(cmd_addr), .cmd_dummy(cmd_dummy), .cmd_tx_data(cmd_tx_data),
    .cmd_tx_bits(cmd_tx_bits), .cmd_rx_bits(cmd_rx_bits), .cmd_done(cmd_done),
    .cmd_rx_data(cmd_rx_data), .seq_done(seq_done), .seq_err_id(seq_err_id),
    .seq_err_timeout(seq_err_timeout), .swap_en(swap_en)
  );

  int checks = 0;
  int fails = 0;
  int n_log = 0;
  int stab_err = 0;
  int busy_left = 0;
  bit busy_forever = 1'b0;
  logic [7:0] sr_val, cr_val, base_val, ord_val;
  logic [75:0] log_cmd [64];

  function automatic logic [75:0] pack_cmd(input logic [7:0] op, input logic [5:0] al,
      input logic [31:0] ad, input logic [3:0] du, input logic [15:0] tx,
      input logic [4:0] tb, input logic [4:0] rb);
    return {op, al, ad, du, tx, tb, rb};
  endfunction

  function automatic logic [75:0] cur_cmd();
    return pack_cmd(cmd_opcode, cmd_addr_len, cmd_addr, cmd_dummy, cmd_tx_data,
                    cmd_tx_bits, cmd_rx_bits);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [75:0] act, input logic [75:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Command engine model: answers two cycles after a request, one done pulse.
  initial begin
    forever begin
      @(negedge clk);
      if (cmd_req) begin
        logic [75:0] held;
        held = cur_cmd();
        if (n_log < 64) log_cmd[n_log] = held;
        n_log++;
        repeat (2) begin
          @(negedge clk);
          if (!cmd_req || cur_cmd() != held) stab_err++;
        end
        if (cmd_opcode == 8'h05) begin
          if (busy_forever || busy_left > 0) begin
            if (busy_left > 0) busy_left--;
            cmd_rx_data = 8'h03;
          end else cmd_rx_data = sr_val;
        end else if (cmd_opcode == 8'h15) cmd_rx_data = cr_val;
        else if (cmd_opcode == 8'h5A) begin
          if (cmd_addr == 32'h0C) cmd_rx_data = base_val;
          else if (cmd_addr == {24'h0, base_val} + 32'h47) cmd_rx_data = ord_val;
          else cmd_rx_data = 8'hEE;
        end else cmd_rx_data = 8'h00;
        cmd_done = 1'b1;
        @(negedge clk);
        cmd_done = 1'b0;
        if (cmd_req) stab_err++;
      end
    end
  end

  task automatic run(input logic [23:0] id, input logic dtr, input bit stray);
    n_log = 0;
    stab_err = 0;
    @(negedge clk);
    jedec_id = id; dtr_mode = dtr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (stray) begin
      repeat (20) @(negedge clk);
      start = 1'b1; dtr_mode = ~dtr;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 5000; i++) begin
      if (seq_done) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk({seq_done, seq_err_id, seq_err_timeout, swap_en, cmd_req} == 5'b0, "R10 reset",
        76'({seq_done, seq_err_id, seq_err_timeout, swap_en, cmd_req}), 76'(0));
  endtask

  task automatic t_bad_id();
    busy_forever = 1'b0; busy_left = 0;
    run(24'hC38118, 1'b0, 1'b0);
    chk(seq_done && seq_err_id && !seq_err_timeout, "R1 wrong vendor",
        76'({seq_done, seq_err_id, seq_err_timeout}), 76'(3'b110));
    chk(n_log == 0, "R1 no command on wrong vendor", 76'(n_log), 76'(0));
    run(24'hC27018, 1'b1, 1'b0);
    chk(seq_done && seq_err_id && !swap_en, "R1 wrong type nibble",
        76'({seq_done, seq_err_id, swap_en}), 76'(3'b110));
    chk(n_log == 0, "R1 no command on wrong type", 76'(n_log), 76'(0));
  endtask

  task automatic t_str();
    logic [75:0] exp [10];
    busy_left = 2; sr_val = 8'h5C; cr_val = 8'hA5; base_val = 8'h00; ord_val = 8'hFF;
    exp[0] = pack_cmd(8'h05, 6'd0, 32'h0, 4'd0, 16'h0, 5'd0, 5'd8);
    exp[1] = exp[0];
    exp[2] = exp[0];
    exp[3] = exp[0];
    exp[4] = pack_cmd(8'h15, 6'd0, 32'h0, 4'd0, 16'h0, 5'd0, 5'd8);
    exp[5] = pack_cmd(8'h06, 6'd0, 32'h0, 4'd0, 16'h0, 5'd0, 5'd0);
    exp[6] = pack_cmd(8'h01, 6'd0, 32'h0, 4'd0, 16'hA75C, 5'd16, 5'd0);
    exp[7] = exp[0];
    exp[8] = exp[5];
    exp[9] = pack_cmd(8'h72, 6'd32, 32'h0, 4'd0, 16'h0001, 5'd8, 5'd0);
    run(24'hC28139, 1'b0, 1'b1);   // stray start mid-run must be ignored (R10)
    chk(n_log == 10, "R3 R8 R9 single-rate command count", 76'(n_log), 76'(10));
    for (int i = 0; i < 10; i++)
      chk(log_cmd[i] == exp[i], (i < 3) ? "R3 poll" : (i < 5) ? "R4 register read" :
          (i < 7) ? "R5 drive write" : "R7 R8 mode write", log_cmd[i], exp[i]);
    chk(seq_done && !seq_err_id && !seq_err_timeout && !swap_en, "R9 R10 single-rate finish",
        76'({seq_done, seq_err_id, seq_err_timeout, swap_en}), 76'(4'b1000));
    chk(stab_err == 0, "R2 fields held and gap", 76'(stab_err), 76'(0));
    @(negedge clk);
    chk(!seq_done && !swap_en, "R10 done is one pulse", 76'({seq_done, swap_en}), 76'(0));
  endtask

  task automatic t_dtr(input logic [7:0] sr, input logic [7:0] cr, input logic [7:0] base,
                       input logic [7:0] ord);
    logic [75:0] exp [10];
    logic [7:0] ncr;
    busy_left = 0; busy_forever = 1'b0;
    sr_val = sr; cr_val = cr; base_val = base; ord_val = ord;
    ncr = {cr[7:3], 3'b111};
    exp[0] = pack_cmd(8'h05, 6'd0, 32'h0, 4'd0, 16'h0, 5'd0, 5'd8);
    exp[1] = exp[0];
    exp[2] = pack_cmd(8'h15, 6'd0, 32'h0, 4'd0, 16'h0, 5'd0, 5'd8);
    exp[3] = pack_cmd(8'h06, 6'd0, 32'h0, 4'd0, 16'h0, 5'd0, 5'd0);
    exp[4] = pack_cmd(8'h01, 6'd0, 32'h0, 4'd0, {ncr, sr}, 5'd16, 5'd0);
    exp[5] = exp[0];
    exp[6] = pack_cmd(8'h5A, 6'd24, 32'h0C, 4'd8, 16'h0, 5'd0, 5'd8);
    exp[7] = pack_cmd(8'h5A, 6'd24, {24'h0, base} + 32'h47, 4'd8, 16'h0, 5'd0, 5'd8);
    exp[8] = exp[3];
    exp[9] = pack_cmd(8'h72, 6'd32, 32'h0, 4'd0, 16'h0002, 5'd8, 5'd0);
    run(24'hC2853A, 1'b1, 1'b0);
    chk(n_log == 10, "R8 double-rate command count", 76'(n_log), 76'(10));
    for (int i = 0; i < 10; i++)
      chk(log_cmd[i] == exp[i], (i < 3) ? "R4 poll/read" : (i < 5) ? "R5 drive write" :
          (i < 8) ? "R6 parameter probe" : "R7 mode write", log_cmd[i], exp[i]);
    chk(seq_done && !seq_err_id && !seq_err_timeout && swap_en == ord[7], "R6 swap flag",
        76'({seq_done, seq_err_id, seq_err_timeout, swap_en}), 76'({3'b100, ord[7]}));
    chk(stab_err == 0, "R2 fields held and gap", 76'(stab_err), 76'(0));
  endtask

  task automatic t_timeout();
    busy_forever = 1'b1;
    run(24'hC28038, 1'b1, 1'b0);
    busy_forever = 1'b0;
    chk(seq_done && seq_err_timeout && !seq_err_id && !swap_en, "R3 timeout flags",
        76'({seq_done, seq_err_timeout, seq_err_id, swap_en}), 76'(4'b1100));
    chk(n_log == 8, "R3 poll count before timeout", 76'(n_log), 76'(8));
    repeat (10) @(negedge clk);
    chk(n_log == 8 && seq_err_timeout, "R3 no command after timeout, flag held",
        76'({n_log, seq_err_timeout}), 76'({32'd8, 1'b1}));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R10 actual=hang expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bad_id();
    t_str();
    t_dtr(8'h00, 8'h07, 8'h30, 8'h80);
    t_timeout();
    t_dtr(8'h02, 8'hF8, 8'hFC, 8'h7F);
    chk(!seq_err_timeout, "R10 error cleared by new start", 76'(seq_err_timeout), 76'(0));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule